// File: doc/BRIEF.md
# Block Pulse-Density Gate Generator

This block drives the gate of one rectifier switch. Time is split into blocks of sixteen switching cycles. At the start of each block the block takes three values: a density, which is the number of cycles in the block that carry a pulse; a placement style, which decides where in the block those cycles fall; and a pulse width in clock ticks. The width comes from a separate power-regulation loop.

An external strobe marks the start of every switching cycle. A position counter advances on each strobe. For each cycle, the density, the style and the position together decide whether that cycle gets a pulse. An enabled cycle produces one gate pulse of exactly the latched width.

The caller must keep the width shorter than the switching period. Three styles are available:

- Contiguous placement, which gives the fewest transitions.
- Evenly spread placement, which gives smoother current.
- A mixed placement, where each half of the block is filled from its own start.

Top module: `pdm_gate_gen`

## Requirements
- R1: A block is 16 strobed cycles. The cycle position starts at 0, advances by one only on a strobe, wraps from 15 to 0, and the placement repeats every block.
- R2: Density, style and width are sampled only on the strobe that begins a block (position 0). Changing them on any other cycle has no effect on the gate until the next block.
- R3: In an enabled cycle, the gate rises on the clock after the strobe and stays high for exactly the latched width in clock periods. A width of 0 gives no pulse. The gate never rises unless the strobe was high on the previous clock.
- R4: Style code 0 (contiguous), and the spare code 3, enable cycle positions i with i < n, where n is the effective density.
- R5: Style code 1 (spread) enables position i if and only if floor((i+1)*n/16) > floor(i*n/16).
- R6: Style code 2 (mixed) enables position i < 8 when i < ceil(n/2), and enables position i >= 8 when i-8 < floor(n/2).
- R7: The 5-bit density counts sixteenths. A density of 0 enables no cycle, 16 enables all cycles, and any value above 16 is treated as 16.
- R8: While rst_n is low, the gate is low and the position returns to 0. The first strobe after reset starts a new block.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_strobe | input | 1 | One-clock pulse at the start of each switching cycle |
| style | input | 2 | Placement style: 0 contiguous, 1 spread, 2 mixed, 3 as 0 |
| density | input | 5 | Pulses per block, in sixteenths |
| pulse_ticks | input | 8 | Gate pulse width in clock ticks |
| gate | output | 1 | Switch gate drive |

## Verification
A position counter that slips by one cycle moves every placement. The mismatch shows in the per-cycle pulse count within the same block, and from then on it persists in every later block. A wrong latch point shows up in the block where the inputs are changed in mid-block: the pulses of that block's remaining cycles take the new density, style or width instead of the old ones. A pulse counter that reloads or drains wrongly shows as a pulse length differing from the width in the very first enabled cycle.

// File: rtl/pdm_gate_gen.sv
module pdm_gate_gen #(
  parameter int BLK_LEN = 16,
  parameter int DW      = 5,
  parameter int TW      = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cyc_strobe,
  input  logic [1:0]    style,
  input  logic [DW-1:0] density,
  input  logic [TW-1:0] pulse_ticks,
  output logic          gate
);
  localparam int PW = $clog2(BLK_LEN);
  localparam logic [PW-1:0] LAST = PW'(BLK_LEN - 1);
  localparam logic [DW-1:0] FULL = DW'(BLK_LEN);

  logic [PW-1:0] pos;
  logic [DW-1:0] dens_q;
  logic [1:0]    style_q;
  logic [TW-1:0] ticks_q;
  logic [TW-1:0] cnt;

  wire           at_start = (pos == '0);
  wire  [DW-1:0] dens_raw = at_start ? density : dens_q;
  wire  [DW-1:0] dens_e   = (dens_raw > FULL) ? FULL : dens_raw;
  wire  [1:0]    style_e  = at_start ? style : style_q;
  wire  [TW-1:0] ticks_e  = at_start ? pulse_ticks : ticks_q;

  function automatic logic slot_on(input int sty, input int n, input int i);
    int half;
    half = BLK_LEN / 2;
    case (sty)
      1:       return ((i + 1) * n / BLK_LEN) != (i * n / BLK_LEN);
      2:       return (i < half) ? (i < (n + 1) / 2) : ((i - half) < n / 2);
      default: return i < n;
    endcase
  endfunction

  logic en;
  always_comb en = slot_on(int'(style_e), int'(dens_e), int'(pos));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pos     <= '0;
      dens_q  <= '0;
      style_q <= '0;
      ticks_q <= '0;
      cnt     <= '0;
    end else if (cyc_strobe) begin
      pos <= (pos == LAST) ? '0 : pos + 1'b1;
      if (at_start) begin
        dens_q  <= dens_e;
        style_q <= style;
        ticks_q <= pulse_ticks;
      end
      cnt <= en ? ticks_e : '0;
    end else if (cnt != '0) begin
      cnt <= cnt - 1'b1;
    end
  end

  assign gate = (cnt != '0);
endmodule

// File: rtl/pdm_gate_gen_chk.sv
module pdm_gate_gen_chk #(
  parameter int PW      = 4,
  parameter int TW      = 8,
  parameter int BLK_LEN = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cyc_strobe,
  input logic          gate,
  input logic [PW-1:0] pos,
  input logic [TW-1:0] cnt
);
  localparam logic [PW-1:0] LAST = PW'(BLK_LEN - 1);

  assert_reset_idle_R8: assert property (@(posedge clk)
    !rst_n |-> (!gate && pos == '0));

  assert_rise_needs_strobe_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(gate) |-> $past(cyc_strobe));

  assert_pos_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !cyc_strobe |=> $stable(pos));

  assert_pos_step_R1: assert property (@(posedge clk) disable iff (!rst_n)
    cyc_strobe |=> pos == (($past(pos) == LAST) ? '0 : $past(pos) + 1'b1));

  assert_width_drain_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt != '0 && !cyc_strobe) |=> cnt == $past(cnt) - 1'b1);
endmodule

bind pdm_gate_gen pdm_gate_gen_chk #(.PW(PW), .TW(TW), .BLK_LEN(BLK_LEN)) u_chk (
  .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .gate(gate),
  .pos(pos), .cnt(cnt)
);

// File: tb/pdm_gate_gen_tb.sv
`timescale 1ns/1ps
module pdm_gate_gen_tb;
  localparam int PER = 20;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cyc_strobe = 1'b0;
  logic [1:0] style = '0;
  logic [4:0] density = '0;
  logic [7:0] pulse_ticks = '0;
  logic       gate;

  int n_chk = 0;
  int n_bad = 0;
  int exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  pdm_gate_gen u_dut (
    .clk(clk), .rst_n(rst_n), .cyc_strobe(cyc_strobe), .style(style),
    .density(density), .pulse_ticks(pulse_ticks), .gate(gate)
  );

  function automatic bit exp_on(int sty, int n, int i);
    case (sty)
      1:       return ((i + 1) * n / 16) > (i * n / 16);
      2:       return (i < 8) ? (i < (n + 1) / 2) : ((i - 8) < n / 2);
      default: return i < n;
    endcase
  endfunction

  task automatic run_cycles(int dens, int sty, int d, int ncyc, string tag);
    int n;
    n = (dens > 16) ? 16 : dens;
    for (int i = 0; i < ncyc; i++) begin
      exp_q.push_back(exp_on(sty, n, i) ? d : 0);
      tag_q.push_back($sformatf("%s/R2/R1 cyc%0d", tag, i));
      if (i == 0) begin
        density = 5'(dens); style = 2'(sty); pulse_ticks = 8'(d);
      end
      @(negedge clk); cyc_strobe = 1'b1;
      @(negedge clk); cyc_strobe = 1'b0;
      if (i == 0) begin
        density = 5'((dens + 7) % 32); style = 2'((sty + 1) % 4);
        pulse_ticks = 8'((d + 5) % PER);
      end
      repeat (PER - 2) @(negedge clk);
    end
  endtask

  task automatic check_reset(string what);
    @(negedge clk);
    n_chk++;
    if (gate !== 1'b0) begin
      n_bad++;
      $display("FAIL R8 %s: gate=%b expected 0", what, gate);
    end
  endtask

  initial begin : monitor
    int hi;
    int e;
    string t;
    forever begin
      @(posedge clk);
      if (cyc_strobe && rst_n) begin
        hi = 0;
        repeat (PER) begin
          @(negedge clk);
          if (gate) hi++;
        end
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        n_chk++;
        if (hi != e) begin
          n_bad++;
          $display("FAIL %s: gate high %0d ticks, expected %0d", t, hi, e);
        end
      end
    end
  end

  initial begin : watchdog
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    check_reset("initial");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_cycles(5, 0, 7, 16, "R4 contiguous d5");
    run_cycles(9, 3, 6, 16, "R4 spare code d9");
    run_cycles(5, 1, 3, 16, "R5 spread d5");
    run_cycles(10, 1, 9, 16, "R5 spread d10");
    run_cycles(15, 1, 2, 16, "R5 spread d15");
    run_cycles(7, 2, 4, 16, "R6 mixed d7");
    run_cycles(12, 2, 11, 16, "R6 mixed d12");
    run_cycles(0, 1, 8, 16, "R7 zero density");
    run_cycles(16, 1, 5, 16, "R7 full density");
    run_cycles(31, 0, 6, 16, "R7 clamp d31");
    run_cycles(17, 2, 3, 16, "R7 clamp d17");
    run_cycles(16, 0, 0, 16, "R3 zero width");
    run_cycles(3, 0, 19, 16, "R3 max width");
    run_cycles(6, 1, 4, 6, "R8 partial block");
    repeat (PER) @(negedge clk);
    rst_n = 1'b0;
    check_reset("mid-block");
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    run_cycles(4, 0, 5, 16, "R8 restart at 0");
    wait (exp_q.size() == 0);
    repeat (PER + 2) @(negedge clk);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule